// File: doc/BRIEF.md
# DDR2 Read Data Return Pipeline

This block models, at clock level, the device-side read path of a DDR2-style memory. The command port carries five kinds of command: row activate, row precharge, READ, and two configuration writes. One configuration write sets the CAS latency and the other sets the additive latency. A READ names a bank, a starting column, a burst length of 4 or 8 words and an auto-precharge flag. After a delay equal to the sum of the two latencies, the block returns the burst as two words per clock, one for the rising half and one for the falling half. Alongside the data it drives a strobe and the strobe's complement.

The strobe has a one-clock low preamble before the first data pair. The strobe stays low in the second half of every data clock, so the last word always leaves with the strobe low, which forms the postamble. When no burst follows, the data and strobe enables drop, which stands for high impedance. Two READs spaced half a burst apart form one unbroken stream. An 8-word burst without auto-precharge can be cut after its first four words by a READ issued two clocks after it. The data comes from a small internal array filled with a fixed pattern.

Top module: `rdPipe`

## Requirements
- R1: After reset all outputs are 0, CAS latency is 3 and additive latency is 0, so the first READ returns data 3 clocks after it is sampled.
- R2: A READ sampled at clock edge k places its first data pair on the outputs right after edge k+AL+CL.
- R3: A CAS latency write (cmdOp 4) loads cmdArg only when it is 3 to 6. An additive latency write (cmdOp 5) loads cmdArg only when it is 0 to 4. Values outside these ranges leave the latency unchanged.
- R4: The word at bank b, column c is {b as 8 bits, c XOR 8'hA5}. Beat i of a burst reads column (c & ~(n-1)) | ((c+i) & (n-1)), where n is the burst length. Data clock j carries beat 2j on dqRise and beat 2j+1 on dqFall.
- R5: A burst of 4 words (cmdBl8=0) keeps dqOe high for 2 clocks. A burst of 8 words (cmdBl8=1) keeps it high for 4 clocks.
- R6: In the clock before a burst's first data pair, if no earlier burst is still delivering data, dqsOe=1, dqOe=0, dqs=2'b00 and dqsN=2'b11.
- R7: In every data clock, dqsOe=1, dqs=2'b10 and dqsN=2'b01 (bit 1 is the rising half). The last word therefore leaves with the strobe low.
- R8: When no burst or preamble is due, dqOe, dqsOe, dqs, dqsN, dqRise and dqFall are all 0.
- R9: A READ sampled n/2 clocks after the previous READ continues the stream with no gap and no preamble.
- R10: An 8-word burst without auto-precharge, followed by a READ two clocks later, delivers only its first 4 words before the new burst.
- R11: Activate (cmdOp 1) opens a bank and precharge (cmdOp 2) closes it. A READ (cmdOp 3) to a closed bank raises rdErr for the next clock and starts no burst. A burst with auto-precharge closes its bank at the edge that ends its last data clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | 0 none, 1 activate, 2 precharge, 3 READ, 4 CAS latency write, 5 additive latency write |
| cmdBank | input | 2 | Bank address |
| cmdCol | input | 6 | Starting column |
| cmdBl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cmdAp | input | 1 | Auto-precharge at end of burst |
| cmdArg | input | 3 | Value for the latency writes |
| dqRise | output | 16 | Word for the rising half of the clock |
| dqFall | output | 16 | Word for the falling half of the clock |
| dqOe | output | 1 | Data output enable |
| dqs | output | 2 | Strobe level {rising half, falling half} |
| dqsN | output | 2 | Complement strobe level |
| dqsOe | output | 1 | Strobe output enable |
| rdErr | output | 1 | One-clock pulse for a READ to a closed bank |

## Verification
Isolated READs are issued with aligned and unaligned starting columns, so the wrap inside the 4-word or 8-word block shows up as a distinct word order, and at more than one latency setting, so that each summed latency gives a different first-data clock. The bench also tries READ pairs spaced exactly half a burst apart and 8-word bursts followed two clocks later by another READ. These two spacings separate seamless joining, truncation and a stray preamble from one another. READs to banks closed by precharge and by auto-precharge check the error pulse, and rejected latency writes must leave the later timing unchanged.

// File: rtl/rdPipePkg.sv
package rdPipePkg;
  parameter int BANK_W = 2;
  parameter int COL_W  = 6;
  parameter int WORD_W = 16;
  parameter int ARG_W  = 3;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_ACT = 3'd1, OP_PRE = 3'd2,
    OP_RD = 3'd3, OP_SETCL = 3'd4, OP_SETAL = 3'd5
  } cmdOp_e;

  typedef struct packed {
    logic             valid;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic             bl8;
    logic             ap;
  } rdSlot_t;

  typedef struct packed {
    logic             dataEn;
    logic             preEn;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  colA;
    logic [COL_W-1:0]  colB;
  } dpStrobe_t;

  function automatic logic [COL_W-1:0] wrapCol(input logic [COL_W-1:0] col,
                                               input logic bl8,
                                               input logic [2:0] idx);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;
    mask = bl8 ? COL_W'(7) : COL_W'(3);
    sum  = col + COL_W'(idx);
    return (col & ~mask) | (sum & mask);
  endfunction

  function automatic logic [WORD_W-1:0] cellWord(input logic [BANK_W-1:0] bank,
                                                 input logic [COL_W-1:0] col);
    return WORD_W'({8'(bank), 8'(col) ^ 8'hA5});
  endfunction
endpackage

// File: rtl/rdCtrl.sv
module rdCtrl
  import rdPipePkg::*;
#(
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6,
  parameter int AL_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              cmdBl8,
  input  logic              cmdAp,
  input  logic [ARG_W-1:0]  cmdArg,
  output dpStrobe_t         strb,
  output logic              rdErr
);
  localparam int RL_MAX    = AL_MAX + CL_MAX;
  localparam int LAT_W     = $clog2(RL_MAX + 1);
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam logic [ARG_W-1:0] CL_LO = ARG_W'(CL_MIN);
  localparam logic [ARG_W-1:0] CL_HI = ARG_W'(CL_MAX);
  localparam logic [ARG_W-1:0] AL_HI = ARG_W'(AL_MAX);

  cmdOp_e op;
  assign op = cmdOp_e'(cmdOp);

  logic [LAT_W-1:0]     clReg, alReg, rl, dataIdx, preIdx;
  logic [NUM_BANKS-1:0] bankOpen;
  rdSlot_t              pipe [RL_MAX];
  rdSlot_t              tapData, tapPre, newSlot;
  logic                 active, curBl8, curAp;
  logic [2:0]           left, nLeft;
  logic [1:0]           pair, nPair;
  logic                 nActive, apClose, accept;
  logic [BANK_W-1:0]    curBank;
  logic [COL_W-1:0]     curCol;

  assign rl      = alReg + clReg;
  assign dataIdx = rl - LAT_W'(1);
  assign preIdx  = rl - LAT_W'(2);
  assign tapData = pipe[dataIdx];
  assign tapPre  = pipe[preIdx];
  assign accept  = (op == OP_RD) && bankOpen[cmdBank];
  assign newSlot = '{valid: accept, bank: cmdBank, col: cmdCol, bl8: cmdBl8, ap: cmdAp};

  always_comb begin
    nActive = active;
    nLeft   = left;
    nPair   = pair;
    strb    = '0;
    if (tapData.valid) begin
      nActive     = 1'b1;
      nLeft       = tapData.bl8 ? 3'd4 : 3'd2;
      nPair       = 2'd0;
      strb.dataEn = 1'b1;
      strb.bank   = tapData.bank;
      strb.colA   = wrapCol(tapData.col, tapData.bl8, 3'd0);
      strb.colB   = wrapCol(tapData.col, tapData.bl8, 3'd1);
    end else if (active && left > 3'd1) begin
      nLeft       = left - 3'd1;
      nPair       = pair + 2'd1;
      strb.dataEn = 1'b1;
      strb.bank   = curBank;
      strb.colA   = wrapCol(curCol, curBl8, {nPair, 1'b0});
      strb.colB   = wrapCol(curCol, curBl8, {nPair, 1'b1});
    end else begin
      nActive = 1'b0;
    end
    strb.preEn = tapPre.valid && !strb.dataEn;
  end

  assign apClose = active && curAp && (left == 3'd1 || tapData.valid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clReg    <= LAT_W'(CL_MIN);
      alReg    <= '0;
      bankOpen <= '0;
      for (int i = 0; i < RL_MAX; i++) pipe[i] <= '0;
      active   <= 1'b0;
      left     <= '0;
      pair     <= '0;
      curBank  <= '0;
      curCol   <= '0;
      curBl8   <= 1'b0;
      curAp    <= 1'b0;
      rdErr    <= 1'b0;
    end else begin
      pipe[0] <= newSlot;
      for (int i = 1; i < RL_MAX; i++) pipe[i] <= pipe[i-1];
      if (tapData.valid) begin
        curBank <= tapData.bank;
        curCol  <= tapData.col;
        curBl8  <= tapData.bl8;
        curAp   <= tapData.ap;
      end
      active <= nActive;
      left   <= nLeft;
      pair   <= nPair;
      rdErr  <= (op == OP_RD) && !bankOpen[cmdBank];
      if (apClose) bankOpen[curBank] <= 1'b0;
      case (op)
        OP_ACT:   bankOpen[cmdBank] <= 1'b1;
        OP_PRE:   bankOpen[cmdBank] <= 1'b0;
        OP_SETCL: if (cmdArg >= CL_LO && cmdArg <= CL_HI) clReg <= LAT_W'(cmdArg);
        OP_SETAL: if (cmdArg <= AL_HI) alReg <= LAT_W'(cmdArg);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rdData.sv
module rdData
  import rdPipePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic [WORD_W-1:0] dqRise,
  output logic [WORD_W-1:0] dqFall,
  output logic              dqOe,
  output logic [1:0]        dqs,
  output logic [1:0]        dqsN,
  output logic              dqsOe
);
  localparam int COLS  = 1 << COL_W;
  localparam int CELLS = (1 << BANK_W) * COLS;

  logic [WORD_W-1:0] cells [CELLS];

  for (genvar gi = 0; gi < CELLS; gi++) begin : g_cell
    assign cells[gi] = cellWord(BANK_W'(gi / COLS), COL_W'(gi % COLS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqRise <= '0;
      dqFall <= '0;
      dqOe   <= 1'b0;
      dqs    <= 2'b00;
      dqsN   <= 2'b00;
      dqsOe  <= 1'b0;
    end else begin
      dqOe  <= strb.dataEn;
      dqsOe <= strb.dataEn || strb.preEn;
      if (strb.dataEn) begin
        dqRise <= cells[{strb.bank, strb.colA}];
        dqFall <= cells[{strb.bank, strb.colB}];
        dqs    <= 2'b10;
        dqsN   <= 2'b01;
      end else begin
        dqRise <= '0;
        dqFall <= '0;
        dqs    <= 2'b00;
        dqsN   <= strb.preEn ? 2'b11 : 2'b00;
      end
    end
  end
endmodule

// File: rtl/rdPipe.sv
module rdPipe
  import rdPipePkg::*;
#(
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6,
  parameter int AL_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              cmdBl8,
  input  logic              cmdAp,
  input  logic [ARG_W-1:0]  cmdArg,
  output logic [WORD_W-1:0] dqRise,
  output logic [WORD_W-1:0] dqFall,
  output logic              dqOe,
  output logic [1:0]        dqs,
  output logic [1:0]        dqsN,
  output logic              dqsOe,
  output logic              rdErr
);
  dpStrobe_t strb;

  rdCtrl #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdCol(cmdCol),
    .cmdBl8(cmdBl8), .cmdAp(cmdAp), .cmdArg(cmdArg), .strb(strb), .rdErr(rdErr)
  );

  rdData u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .dqRise(dqRise), .dqFall(dqFall),
    .dqOe(dqOe), .dqs(dqs), .dqsN(dqsN), .dqsOe(dqsOe)
  );
endmodule

// File: rtl/rdPipeChk.sv
module rdPipeChk (
  input logic       clk,
  input logic       rstN,
  input logic       dqOe,
  input logic [1:0] dqs,
  input logic [1:0] dqsN,
  input logic       dqsOe
);
  // R6
  preamble_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> ($past(dqsOe) && !$past(dqOe)));

  // R6
  preamble_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dqsOe && !dqOe) |-> (dqs == 2'b00 && dqsN == 2'b11));

  // R7
  data_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (dqsOe && dqs == 2'b10 && dqsN == 2'b01));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dqsOe |-> (!dqOe && dqs == 2'b00 && dqsN == 2'b00));
endmodule

bind rdPipe rdPipeChk u_chk (
  .clk(clk), .rstN(rstN), .dqOe(dqOe), .dqs(dqs), .dqsN(dqsN), .dqsOe(dqsOe)
);

// File: tb/rdPipe_bench.sv
`timescale 1ns/1ps
module rdPipe_bench;
  localparam int SLOTS = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [1:0]  cmdBank = '0;
  logic [5:0]  cmdCol = '0;
  logic        cmdBl8 = 1'b0;
  logic        cmdAp = 1'b0;
  logic [2:0]  cmdArg = '0;
  logic [15:0] dqRise, dqFall;
  logic        dqOe, dqsOe, rdErr;
  logic [1:0]  dqs, dqsN;

  rdPipe u_rdPipe (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdCol(cmdCol),
    .cmdBl8(cmdBl8), .cmdAp(cmdAp), .cmdArg(cmdArg), .dqRise(dqRise), .dqFall(dqFall),
    .dqOe(dqOe), .dqs(dqs), .dqsN(dqsN), .dqsOe(dqsOe), .rdErr(rdErr)
  );

  always #2.5 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    checkOn = 1'b0;

  bit          xData [SLOTS];
  bit          xPre  [SLOTS];
  bit          xErr  [SLOTS];
  logic [15:0] xR    [SLOTS];
  logic [15:0] xF    [SLOTS];
  string       xTag  [SLOTS];

  int clM = 3;
  int alM = 0;
  bit openM [4];
  int closeEdge [4];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] refWord(int b, int c);
    return {8'(b), 8'(c) ^ 8'hA5};
  endfunction

  function automatic int beatCol(int c, int n, int i);
    return (c & ~(n - 1)) | ((c + i) & (n - 1));
  endfunction

  task automatic issue(input int op, input int b, input int c, input bit bl8,
                       input bit ap, input int arg, input string tag);
    int e, rl, n;
    @(negedge clk);
    e = cyc + 1;
    cmdOp = 3'(op); cmdBank = 2'(b); cmdCol = 6'(c);
    cmdBl8 = bl8; cmdAp = ap; cmdArg = 3'(arg);
    case (op)
      1: begin openM[b] = 1'b1; closeEdge[b] = 1 << 30; end
      2: openM[b] = 1'b0;
      4: if (arg >= 3 && arg <= 6) clM = arg;
      5: if (arg <= 4) alM = arg;
      3: begin
        if (!openM[b] || e > closeEdge[b]) begin
          xErr[e] = 1'b1;
          xTag[e] = "R11";
        end else begin
          rl = clM + alM;
          n = bl8 ? 8 : 4;
          xPre[e + rl - 1] = 1'b1;
          for (int j = 0; j < n / 2; j++) begin
            xData[e + rl + j] = 1'b1;
            xR[e + rl + j] = refWord(b, beatCol(c, n, 2 * j));
            xF[e + rl + j] = refWord(b, beatCol(c, n, 2 * j + 1));
            xTag[e + rl + j] = tag;
          end
          if (ap) closeEdge[b] = e + rl + n / 2;
        end
      end
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmdOp = 3'd0;
    end
  endtask

  always @(negedge clk) begin
    if (checkOn && cyc < SLOTS) begin
      logic [15:0] eR, eF;
      logic [1:0]  eDqs, eDqsN;
      bit eOe, eSoe;
      string t;
      eOe = xData[cyc];
      eSoe = xData[cyc] || xPre[cyc];
      eR = xData[cyc] ? xR[cyc] : 16'h0;
      eF = xData[cyc] ? xF[cyc] : 16'h0;
      eDqs = xData[cyc] ? 2'b10 : 2'b00;
      eDqsN = xData[cyc] ? 2'b01 : (xPre[cyc] ? 2'b11 : 2'b00);
      t = xData[cyc] ? xTag[cyc] : (xPre[cyc] ? "R6" : (xErr[cyc] ? "R11" : xTag[cyc]));
      checks++;
      if (dqOe !== eOe || dqsOe !== eSoe || dqRise !== eR || dqFall !== eF ||
          dqs !== eDqs || dqsN !== eDqsN || rdErr !== xErr[cyc]) begin
        errors++;
        $display("FAIL %s cycle %0d: actual oe=%b soe=%b r=%h f=%h dqs=%b dqsN=%b err=%b expected oe=%b soe=%b r=%h f=%h dqs=%b dqsN=%b err=%b",
                 t, cyc, dqOe, dqsOe, dqRise, dqFall, dqs, dqsN, rdErr,
                 eOe, eSoe, eR, eF, eDqs, eDqsN, xErr[cyc]);
      end
    end
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      xData[i] = 1'b0; xPre[i] = 1'b0; xErr[i] = 1'b0;
      xR[i] = '0; xF[i] = '0; xTag[i] = (i < 12) ? "R1" : "R8";
    end
    for (int b = 0; b < 4; b++) begin openM[b] = 1'b0; closeEdge[b] = 1 << 30; end
    checkOn = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // R1: default latency of 3 after reset; R2 first-data timing
    issue(1, 1, 0, 0, 0, 0, "");
    issue(3, 1, 4, 0, 0, 0, "R1");
    idle(10);
    issue(3, 1, 8, 0, 0, 0, "R2");
    idle(10);
    // R4: unaligned starts wrap inside the block
    issue(3, 1, 6, 1, 0, 0, "R4");
    idle(10);
    issue(3, 1, 45, 0, 0, 0, "R4");
    idle(10);
    // R5: both burst lengths; R7 strobe during data
    issue(3, 1, 16, 0, 0, 0, "R5");
    idle(10);
    issue(3, 1, 24, 1, 0, 0, "R5");
    idle(10);
    issue(3, 1, 32, 1, 0, 0, "R7");
    idle(10);
    // R11: closed bank by never opening, then by precharge
    issue(3, 2, 0, 0, 0, 0, "R11");
    idle(6);
    issue(1, 2, 0, 0, 0, 0, "");
    issue(2, 2, 0, 0, 0, 0, "");
    issue(3, 2, 3, 1, 0, 0, "R11");
    idle(10);
    // R2: a longer latency, AL=2 CL=5
    issue(4, 0, 0, 0, 0, 5, "");
    issue(5, 0, 0, 0, 0, 2, "");
    idle(2);
    issue(3, 1, 12, 1, 0, 0, "R2");
    idle(14);
    // R3: out-of-range writes ignored
    issue(4, 0, 0, 0, 0, 7, "");
    issue(5, 0, 0, 0, 0, 5, "");
    issue(4, 0, 0, 0, 0, 2, "");
    idle(2);
    issue(3, 1, 50, 0, 0, 0, "R3");
    idle(14);
    issue(4, 0, 0, 0, 0, 4, "");
    issue(5, 0, 0, 0, 0, 0, "");
    idle(2);
    // R9: seamless joins of 4, 4, 8 then 8, 8
    issue(3, 1, 1, 0, 0, 0, "R9");
    idle(1);
    issue(3, 1, 9, 0, 0, 0, "R9");
    idle(1);
    issue(3, 1, 18, 1, 0, 0, "R9");
    idle(3);
    issue(3, 1, 27, 1, 0, 0, "R9");
    idle(12);
    // R10: 8-word burst cut after four words
    issue(3, 1, 40, 1, 0, 0, "R10");
    idle(1);
    issue(3, 1, 60, 0, 0, 0, "R10");
    idle(12);
    issue(3, 1, 2, 1, 0, 0, "R10");
    idle(1);
    issue(3, 1, 35, 1, 0, 0, "R10");
    idle(12);
    // R11: auto-precharge closes the bank at end of burst
    issue(1, 3, 0, 0, 0, 0, "");
    issue(3, 3, 20, 0, 1, 0, "R11");
    idle(12);
    issue(3, 3, 20, 0, 0, 0, "R11");
    idle(12);
    // R8: quiet tail
    idle(10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule